// File: doc/BRIEF.md
# Serial Flash Page Program Slave

This block is the target side of a serial flash command port. A host drives a chip select, a serial clock and a serial data line, and gets status back on a serial output. Three commands are decoded: Write Enable (06h), Read Status (05h) and Page Program (02h). Page Program data is gathered into a 256-byte page buffer. Each buffered byte carries a valid flag. When chip select rises at a legal point, a self-timed program cycle walks the buffer and writes each collected byte into an internal byte array. The write is made through a write port that is visible at the block's outputs.

All pins are resampled in the system clock domain. A two-stage synchroniser is followed by an edge detector, so the serial clock must be slower than the system clock. SPI mode 0 and mode 3 both work, because only rising edges are used for input and only falling edges are used for output.

Command state machine (`cmd_state_t`):
- CMD_IDLE goes to CMD_OPCODE on the chip select fall.
- CMD_OPCODE goes to one of three states once the first byte completes:
  - CMD_STATUS for 05h.
  - CMD_ADDR for 02h, but only when the write enable latch is set and the block is not busy.
  - CMD_SKIP for everything else, including 06h.
- CMD_ADDR goes to CMD_DATA after the third address byte.
- Every state returns to CMD_IDLE when chip select rises.

Program engine (`eng_state_t`):
- ENG_IDLE goes to ENG_WRITE on a start pulse.
- ENG_WRITE visits buffer offsets 0 to 255, one per clock, and goes to ENG_WAIT after offset 255.
- ENG_WAIT goes back to ENG_IDLE when the cycle counter reaches the program length.

Top module: `spi_page_prog`

## Requirements
- R1: Input bits are taken on rising serial clock edges, most significant bit first. Output bits change on falling edges. Both idle-low (mode 0) and idle-high (mode 3) clocks work.
- R2: The Read Status command (05h) returns the status byte repeatedly, most significant bit first, for as long as chip select stays low.
  - Bit 0 is write-in-progress (WIP).
  - Bit 1 is the write enable latch (WEL).
  - All other bits are 0.
  - The Write Enable command (06h) sets WEL.
  - `miso` is 0 after reset.
- R3: A Page Program (02h) received while WEL is clear writes nothing, and WIP stays 0.
- R4: A Page Program frame is the opcode, 3 address bytes and then data bytes. The first data byte goes to offset `addr[7:0]` of the addressed page, and the following bytes go to the next offsets. The array writes come out on the write port in ascending offset order, with `arr_addr` = {page, offset}.
- R5: Data that runs past offset 255 continues at offset 0 of the same page.
- R6: When more than 256 data bytes are sent, each offset keeps the last byte received for it.
- R7: Offsets that received no data get no write transaction.
- R8: If chip select rises while the bit count is not a multiple of 8, or before any data byte has arrived, the program is cancelled. Nothing is written and WEL keeps its value.
- R9: WIP reads 1 from a few clocks after a legal chip select rise for PROG_CYCLES clocks, then reads 0. WEL is already 0 while WIP is 1.
- R10: Each written array byte equals the old array byte ANDed with the received byte, so bits can only go from 1 to 0.
- R11: `prot_lvl` sets which pages are locked, and a program aimed at a locked page is not executed.
  - 0 locks none.
  - 1 locks the top quarter of the pages.
  - 2 locks the top half.
  - 3 locks all pages.
- R12: While WIP is 1, Write Enable and Page Program commands are ignored, and Read Status still works.
- R13: Address bits above the array size are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| sclk | input | 1 | Serial clock |
| mosi | input | 1 | Serial data from host |
| miso | output | 1 | Serial status data to host |
| prot_lvl | input | 2 | Lock level (R11 encoding) |
| arr_we | output | 1 | Array write strobe, one per programmed byte |
| arr_addr | output | PGW+8 | Array byte address {page, offset} |
| arr_wdata | output | 8 | Value written (old AND new) |

## Verification
The timing of each result, counted in system clocks from the pin change that causes it:
- A pin change reaches the logic 2 clocks later, and the edge detector needs a third clock.
- A status bit therefore appears on `miso` about 4 clocks after a falling serial edge. The bench samples it 5 clocks after that edge, just before the next rising edge.
- Write-port transactions begin about 5 clocks after chip select rises and end within 260 clocks.
- WIP falls about PROG_CYCLES+5 clocks after chip select rises.

A scoreboard queue holds the expected {address, value} items in offset order, and a monitor compares each write-port strobe against them at the falling clock edge. WIP and WEL are read right after chip select rises, when WIP must be 1. They are read again PROG_CYCLES+30 clocks later, when WIP must be 0.

// File: rtl/pp_pkg.sv
package pp_pkg;
    localparam logic [7:0] OP_WREN = 8'h06;
    localparam logic [7:0] OP_RDSR = 8'h05;
    localparam logic [7:0] OP_PROG = 8'h02;
    localparam int         PAGE_BYTES = 256;

    typedef enum logic [2:0] {
        CMD_IDLE,
        CMD_OPCODE,
        CMD_ADDR,
        CMD_DATA,
        CMD_STATUS,
        CMD_SKIP
    } cmd_state_t;

    typedef enum logic [1:0] {
        ENG_IDLE,
        ENG_WRITE,
        ENG_WAIT
    } eng_state_t;
endpackage

// File: rtl/pp_spi_front.sv
module pp_spi_front #(
    parameter int SYNC = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cs_n_i,
    input  logic       sclk_i,
    input  logic       mosi_i,
    input  logic       tx_en_i,
    input  logic [7:0] tx_byte_i,
    output logic       cs_fall_o,
    output logic       cs_rise_o,
    output logic       rx_valid_o,
    output logic [7:0] rx_byte_o,
    output logic [2:0] bit_phase_o,
    output logic       miso_o
);
    localparam int NSIG  = 3;
    localparam int I_SDI = 0;
    localparam int I_SCK = 1;
    localparam int I_CS  = 2;

    logic [NSIG-1:0] pins;
    logic [NSIG-1:0] synced;
    assign pins = {cs_n_i, sclk_i, mosi_i};

    genvar g;
    generate
        for (g = 0; g < NSIG; g++) begin : g_sync
            localparam logic IDLE_V = (g == I_CS);
            logic [SYNC-1:0] chain;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain <= {SYNC{IDLE_V}};
                else        chain <= {chain[SYNC-2:0], pins[g]};
            end
            assign synced[g] = chain[SYNC-1];
        end
    endgenerate

    logic cs_d, sck_d;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cs_d  <= 1'b1;
            sck_d <= 1'b0;
        end else begin
            cs_d  <= synced[I_CS];
            sck_d <= synced[I_SCK];
        end
    end

    logic cs_act, sck_rise, sck_fall;
    assign cs_act    = !synced[I_CS];
    assign cs_fall_o = cs_d & !synced[I_CS];
    assign cs_rise_o = !cs_d & synced[I_CS];
    assign sck_rise  = cs_act & !sck_d & synced[I_SCK];
    assign sck_fall  = cs_act & sck_d & !synced[I_SCK];

    // receive shifter: rising edges only, MSB first
    logic [7:0] rx_sh;
    logic [2:0] phase;
    logic       rx_v;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_sh <= '0;
            phase <= '0;
            rx_v  <= 1'b0;
        end else if (!cs_act) begin
            phase <= '0;
            rx_v  <= 1'b0;
        end else begin
            rx_v <= 1'b0;
            if (sck_rise) begin
                rx_sh <= {rx_sh[6:0], synced[I_SDI]};
                phase <= phase + 3'd1;
                rx_v  <= (phase == 3'd7);
            end
        end
    end
    assign rx_byte_o   = rx_sh;
    assign rx_valid_o  = rx_v;
    assign bit_phase_o = phase;

    // transmit shifter: falling edges only, reload every 8 bits
    logic [7:0] tx_sh;
    logic [2:0] tx_cnt;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_sh  <= '0;
            tx_cnt <= '0;
        end else if (!cs_act) begin
            tx_sh  <= '0;
            tx_cnt <= '0;
        end else if (tx_en_i && sck_fall) begin
            tx_sh  <= (tx_cnt == 3'd0) ? tx_byte_i : {tx_sh[6:0], 1'b0};
            tx_cnt <= tx_cnt + 3'd1;
        end
    end
    assign miso_o = tx_sh[7];

    // R1: a completed byte always coincides with a wrapped bit phase
    p_byte_aligned_r1: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid_o |-> (bit_phase_o == 3'd0));
    // R2: output is quiet once chip select has been high for a clock
    p_quiet_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_act && !$rose(synced[I_CS])) |=> !miso_o);
endmodule

// File: rtl/pp_cmd_fsm.sv
module pp_cmd_fsm
    import pp_pkg::*;
#(
    parameter int PGW = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           cs_fall_i,
    input  logic           cs_rise_i,
    input  logic           rx_valid_i,
    input  logic [7:0]     rx_byte_i,
    input  logic [2:0]     bit_phase_i,
    input  logic           busy_i,
    input  logic [1:0]     prot_i,
    output logic           tx_en_o,
    output logic [7:0]     status_o,
    output logic           buf_we_o,
    output logic [7:0]     buf_idx_o,
    output logic [7:0]     buf_data_o,
    output logic           buf_clr_o,
    output logic           start_o,
    output logic [PGW-1:0] start_page_o
);
    localparam int           PAGES = 1 << PGW;
    localparam logic [PGW-1:0] TOP_QTR = PGW'(PAGES - PAGES / 4);
    localparam logic [PGW-1:0] TOP_HLF = PGW'(PAGES / 2);

    cmd_state_t state, nxt;

    logic           wel_q;
    logic [1:0]     addr_n;
    logic [PGW-1:0] page_q;
    logic [7:0]     ptr_q;
    logic           got_data;
    logic           start_q;
    logic [PGW-1:0] spage_q;

    function automatic logic page_locked(input logic [PGW-1:0] pg, input logic [1:0] lvl);
        logic r;
        unique case (lvl)
            2'd0:    r = 1'b0;
            2'd1:    r = (pg >= TOP_QTR);
            2'd2:    r = (pg >= TOP_HLF);
            default: r = 1'b1;
        endcase
        return r;
    endfunction

    logic op_done, take_prog, take_wren, accept;
    assign op_done   = (state == CMD_OPCODE) && rx_valid_i;
    assign take_prog = op_done && (rx_byte_i == OP_PROG) && wel_q && !busy_i;
    assign take_wren = op_done && (rx_byte_i == OP_WREN) && !busy_i;
    assign accept    = (state == CMD_DATA) && cs_rise_i && (bit_phase_i == 3'd0)
                       && got_data && !page_locked(page_q, prot_i);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= CMD_IDLE;
        else        state <= nxt;
    end

    // next state
    always_comb begin
        nxt = state;
        if (cs_rise_i) begin
            nxt = CMD_IDLE;
        end else begin
            unique case (state)
                CMD_IDLE:   if (cs_fall_i) nxt = CMD_OPCODE;
                CMD_OPCODE: if (rx_valid_i) begin
                    if (rx_byte_i == OP_RDSR) nxt = CMD_STATUS;
                    else if (take_prog)       nxt = CMD_ADDR;
                    else                      nxt = CMD_SKIP;
                end
                CMD_ADDR:   if (rx_valid_i && addr_n == 2'd2) nxt = CMD_DATA;
                CMD_DATA:   nxt = CMD_DATA;
                CMD_STATUS: nxt = CMD_STATUS;
                CMD_SKIP:   nxt = CMD_SKIP;
                default:    nxt = CMD_IDLE;
            endcase
        end
    end

    // outputs and command registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wel_q    <= 1'b0;
            addr_n   <= '0;
            page_q   <= '0;
            ptr_q    <= '0;
            got_data <= 1'b0;
            start_q  <= 1'b0;
            spage_q  <= '0;
        end else begin
            start_q <= accept;
            if (accept) begin
                spage_q <= page_q;
                wel_q   <= 1'b0;
            end else if (take_wren) begin
                wel_q <= 1'b1;
            end
            if (take_prog) begin
                addr_n   <= '0;
                got_data <= 1'b0;
            end
            if (state == CMD_ADDR && rx_valid_i) begin
                addr_n <= addr_n + 2'd1;
                if (addr_n == 2'd1) page_q <= rx_byte_i[PGW-1:0];
                if (addr_n == 2'd2) ptr_q  <= rx_byte_i;
            end
            if (buf_we_o) begin
                ptr_q    <= ptr_q + 8'd1;
                got_data <= 1'b1;
            end
        end
    end

    assign tx_en_o      = (state == CMD_STATUS);
    assign status_o     = {6'b0, wel_q, busy_i};
    assign buf_we_o     = (state == CMD_DATA) && rx_valid_i;
    assign buf_idx_o    = ptr_q;
    assign buf_data_o   = rx_byte_i;
    assign buf_clr_o    = take_prog;
    assign start_o      = start_q;
    assign start_page_o = spage_q;

    // R9: the latch is already clear when the program cycle is launched
    p_start_clears_wel_r9: assert property (@(posedge clk) disable iff (!rst_n)
        start_o |-> !wel_q);
    // R9: the latch is never set at the moment the cycle ends
    p_wel_gone_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_i) |-> !wel_q);
    // R12: page data is never collected while the engine is busy
    p_no_fill_busy_r12: assert property (@(posedge clk) disable iff (!rst_n)
        buf_we_o |-> !busy_i);
endmodule

// File: rtl/pp_prog_engine.sv
module pp_prog_engine
    import pp_pkg::*;
#(
    parameter int PGW         = 2,
    parameter int PROG_CYCLES = 400
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              buf_we_i,
    input  logic [7:0]        buf_idx_i,
    input  logic [7:0]        buf_data_i,
    input  logic              buf_clr_i,
    input  logic              start_i,
    input  logic [PGW-1:0]    start_page_i,
    output logic              busy_o,
    output logic              arr_we_o,
    output logic [PGW+7:0]    arr_addr_o,
    output logic [7:0]        arr_wdata_o
);
    localparam int AW        = PGW + 8;
    localparam int MEM_BYTES = (1 << PGW) * PAGE_BYTES;
    localparam int TOTAL     = (PROG_CYCLES > 264) ? PROG_CYCLES : 264;
    localparam int CW        = $clog2(TOTAL + 1);

    logic [7:0]            pbuf [PAGE_BYTES];
    logic [PAGE_BYTES-1:0] pval;
    logic [7:0]            mem  [MEM_BYTES];

    eng_state_t state, nxt;
    logic [7:0]     idx;
    logic [CW-1:0]  cnt;
    logic [PGW-1:0] page_q;

    always_ff @(posedge clk) begin
        if (buf_we_i) pbuf[buf_idx_i] <= buf_data_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         pval <= '0;
        else if (buf_clr_i) pval <= '0;
        else if (buf_we_i)  pval[buf_idx_i] <= 1'b1;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ENG_IDLE;
        else        state <= nxt;
    end

    // next state
    always_comb begin
        nxt = state;
        unique case (state)
            ENG_IDLE:  if (start_i) nxt = ENG_WRITE;
            ENG_WRITE: if (idx == 8'hFF) nxt = ENG_WAIT;
            ENG_WAIT:  if (cnt == CW'(TOTAL - 1)) nxt = ENG_IDLE;
            default:   nxt = ENG_IDLE;
        endcase
    end

    logic [AW-1:0] cur_addr;
    logic [7:0]    merged;
    assign cur_addr = {page_q, idx};
    assign merged   = mem[cur_addr] & pbuf[idx];

    // outputs, counters and array update
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx         <= '0;
            cnt         <= '0;
            page_q      <= '0;
            arr_we_o    <= 1'b0;
            arr_addr_o  <= '0;
            arr_wdata_o <= '0;
            for (int i = 0; i < MEM_BYTES; i++) mem[i] <= 8'hFF;
        end else begin
            arr_we_o <= 1'b0;
            unique case (state)
                ENG_IDLE: if (start_i) begin
                    idx    <= '0;
                    cnt    <= '0;
                    page_q <= start_page_i;
                end
                ENG_WRITE: begin
                    idx <= idx + 8'd1;
                    cnt <= cnt + CW'(1);
                    if (pval[idx]) begin
                        arr_we_o      <= 1'b1;
                        arr_addr_o    <= cur_addr;
                        arr_wdata_o   <= merged;
                        mem[cur_addr] <= merged;
                    end
                end
                ENG_WAIT: cnt <= cnt + CW'(1);
                default: ;
            endcase
        end
    end

    assign busy_o = (state != ENG_IDLE);

    // R9: array writes happen only inside the timed cycle
    p_we_in_cycle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        arr_we_o |-> busy_o);
    // R12: no launch is requested while a cycle is running
    p_start_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |-> !busy_o);
    // R4: every write of one cycle stays in the latched page
    p_one_page_r4: assert property (@(posedge clk) disable iff (!rst_n)
        arr_we_o |-> (arr_addr_o[AW-1:8] == page_q));
    // R9: the cycle never ends before its full length
    p_full_len_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> $past(cnt == CW'(TOTAL - 1)));
endmodule

// File: rtl/spi_page_prog.sv
module spi_page_prog #(
    parameter int PAGES       = 4,
    parameter int PROG_CYCLES = 400,
    parameter int SYNC        = 2,
    localparam int PGW        = $clog2(PAGES),
    localparam int AW         = PGW + 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs_n,
    input  logic          sclk,
    input  logic          mosi,
    output logic          miso,
    input  logic [1:0]    prot_lvl,
    output logic          arr_we,
    output logic [AW-1:0] arr_addr,
    output logic [7:0]    arr_wdata
);
    logic           cs_fall, cs_rise, rx_valid, tx_en, busy;
    logic [7:0]     rx_byte, status;
    logic [2:0]     bit_phase;
    logic           buf_we, buf_clr, start;
    logic [7:0]     buf_idx, buf_data;
    logic [PGW-1:0] start_page;

    pp_spi_front #(.SYNC(SYNC)) u_front (
        .clk(clk), .rst_n(rst_n),
        .cs_n_i(cs_n), .sclk_i(sclk), .mosi_i(mosi),
        .tx_en_i(tx_en), .tx_byte_i(status),
        .cs_fall_o(cs_fall), .cs_rise_o(cs_rise),
        .rx_valid_o(rx_valid), .rx_byte_o(rx_byte),
        .bit_phase_o(bit_phase), .miso_o(miso)
    );

    pp_cmd_fsm #(.PGW(PGW)) u_cmd (
        .clk(clk), .rst_n(rst_n),
        .cs_fall_i(cs_fall), .cs_rise_i(cs_rise),
        .rx_valid_i(rx_valid), .rx_byte_i(rx_byte),
        .bit_phase_i(bit_phase), .busy_i(busy), .prot_i(prot_lvl),
        .tx_en_o(tx_en), .status_o(status),
        .buf_we_o(buf_we), .buf_idx_o(buf_idx), .buf_data_o(buf_data),
        .buf_clr_o(buf_clr), .start_o(start), .start_page_o(start_page)
    );

    pp_prog_engine #(.PGW(PGW), .PROG_CYCLES(PROG_CYCLES)) u_eng (
        .clk(clk), .rst_n(rst_n),
        .buf_we_i(buf_we), .buf_idx_i(buf_idx), .buf_data_i(buf_data),
        .buf_clr_i(buf_clr), .start_i(start), .start_page_i(start_page),
        .busy_o(busy),
        .arr_we_o(arr_we), .arr_addr_o(arr_addr), .arr_wdata_o(arr_wdata)
    );
endmodule

// File: tb/spi_page_prog_test.sv
module spi_page_prog_test;
    localparam int PROG = 400;
    localparam int H    = 5;
    localparam int AW   = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1, sclk = 1'b0, mosi = 1'b0;
    logic [1:0] prot_lvl = 2'd0;
    logic miso, arr_we;
    logic [AW-1:0] arr_addr;
    logic [7:0] arr_wdata;

    always #2.5 clk = ~clk;

    spi_page_prog #(.PAGES(4), .PROG_CYCLES(PROG)) uut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .mosi(mosi),
        .miso(miso), .prot_lvl(prot_lvl),
        .arr_we(arr_we), .arr_addr(arr_addr), .arr_wdata(arr_wdata)
    );

    typedef struct packed { logic [AW-1:0] a; logic [7:0] d; } wr_t;
    wr_t exp_q[$];
    logic [7:0] bm [1024];
    int checks = 0, errors = 0, salt = 0;
    string cur_req = "R0";

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // scoreboard monitor
    always @(negedge clk) begin : mon
        wr_t e;
        if (rst_n && arr_we) begin
            if (exp_q.size() == 0) begin
                check(1'b0, cur_req, "unexpected array write", int'(arr_addr), 0);
            end else begin
                e = exp_q.pop_front();
                check(arr_addr == e.a, cur_req, "write address", int'(arr_addr), int'(e.a));
                check(arr_wdata == e.d, cur_req, "write data", int'(arr_wdata), int'(e.d));
            end
        end
    end

    task automatic hc();
        repeat (H) @(negedge clk);
    endtask

    task automatic bitx(input logic b, output logic r);
        sclk = 1'b0; mosi = b;
        hc();
        r = miso; sclk = 1'b1;
        hc();
    endtask

    task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
        for (int i = 7; i >= 0; i--) bitx(tx[i], rx[i]);
    endtask

    task automatic cs_low(input bit mode3);
        sclk = mode3; hc(); cs_n = 1'b0; hc();
    endtask

    task automatic cs_high(input bit mode3);
        sclk = mode3; hc(); cs_n = 1'b1; hc();
    endtask

    task automatic wren(input bit mode3);
        logic [7:0] r;
        cs_low(mode3); xfer(8'h06, r); cs_high(mode3);
    endtask

    task automatic expect_status(input bit mode3, input logic [7:0] exp, input string req);
        logic [7:0] r0, r1;
        cs_low(mode3); xfer(8'h05, r0); xfer(8'h00, r0); xfer(8'h00, r1); cs_high(mode3);
        check(r0 == exp, req, "status byte 1", int'(r0), int'(exp));
        check(r1 == exp, req, "status byte 2", int'(r1), int'(exp));
    endtask

    task automatic settle(input string req);
        repeat (PROG + 30) @(negedge clk);
        check(exp_q.size() == 0, req, "writes still pending", exp_q.size(), 0);
    endtask

    task automatic run_pp(input logic [23:0] a, input int n, input int tail_bits,
                          input bit exec, input bit mode3, input string req);
        logic [7:0] pb [256];
        bit pv [256];
        logic [7:0] r, d;
        wr_t e;
        cur_req = req;
        salt++;
        for (int o = 0; o < 256; o++) pv[o] = 1'b0;
        for (int i = 0; i < n; i++) begin
            d = 8'(salt * 37 + i * 13 + 5);
            pb[(int'(a[7:0]) + i) % 256] = d;
            pv[(int'(a[7:0]) + i) % 256] = 1'b1;
        end
        if (exec) begin
            for (int o = 0; o < 256; o++) begin
                if (pv[o]) begin
                    e.a = {a[9:8], 8'(o)};
                    e.d = bm[e.a] & pb[o];
                    bm[e.a] = e.d;
                    exp_q.push_back(e);
                end
            end
        end
        cs_low(mode3);
        xfer(8'h02, r);
        xfer(a[23:16], r); xfer(a[15:8], r); xfer(a[7:0], r);
        for (int i = 0; i < n; i++) xfer(8'(salt * 37 + i * 13 + 5), r);
        for (int i = 0; i < tail_bits; i++) bitx(1'b1, r);
        cs_high(mode3);
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        check(1'b0, "WD", "watchdog expired", 1, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        for (int i = 0; i < 1024; i++) bm[i] = 8'hFF;
        repeat (10) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        check(miso == 1'b0, "R2", "miso after reset", int'(miso), 0);
        expect_status(1'b0, 8'h00, "R2");

        // R2/R1: write enable seen in both clock modes
        wren(1'b0);
        expect_status(1'b0, 8'h02, "R2");
        expect_status(1'b1, 8'h02, "R1");

        // R4/R7/R9: short program, status during and after cycle
        run_pp(24'h000010, 4, 0, 1'b1, 1'b0, "R4");
        expect_status(1'b0, 8'h01, "R9");
        settle("R7");
        expect_status(1'b0, 8'h00, "R9");

        // R3: program without write enable
        run_pp(24'h000100, 3, 0, 1'b0, 1'b0, "R3");
        expect_status(1'b0, 8'h00, "R3");
        settle("R3");

        // R5/R1: mode 3 wrap past offset 255
        wren(1'b1);
        run_pp(24'h0002FC, 8, 0, 1'b1, 1'b1, "R5");
        settle("R5");

        // R10: reprogram same bytes, result is AND
        wren(1'b0);
        run_pp(24'h000010, 4, 0, 1'b1, 1'b0, "R10");
        settle("R10");

        // R6: more than a page of data
        wren(1'b0);
        run_pp(24'h000380, 300, 0, 1'b1, 1'b0, "R6");
        settle("R6");

        // R8: misaligned chip select rise, then zero data bytes
        wren(1'b0);
        run_pp(24'h000020, 5, 3, 1'b0, 1'b0, "R8");
        settle("R8");
        expect_status(1'b0, 8'h02, "R8");
        run_pp(24'h000020, 0, 0, 1'b0, 1'b0, "R8");
        settle("R8");
        expect_status(1'b0, 8'h02, "R8");

        // R11: lock levels
        prot_lvl = 2'd1;
        run_pp(24'h000340, 2, 0, 1'b0, 1'b0, "R11");
        settle("R11");
        expect_status(1'b0, 8'h02, "R11");
        run_pp(24'h000240, 2, 0, 1'b1, 1'b0, "R11");
        settle("R11");
        prot_lvl = 2'd2;
        wren(1'b0);
        run_pp(24'h000250, 2, 0, 1'b0, 1'b0, "R11");
        settle("R11");
        run_pp(24'h000150, 2, 0, 1'b1, 1'b0, "R11");
        settle("R11");
        prot_lvl = 2'd3;
        wren(1'b0);
        run_pp(24'h000060, 2, 0, 1'b0, 1'b0, "R11");
        settle("R11");
        expect_status(1'b0, 8'h02, "R11");
        prot_lvl = 2'd0;

        // R12: write enable ignored while busy
        run_pp(24'h000070, 2, 0, 1'b1, 1'b0, "R12");
        wren(1'b0);
        expect_status(1'b0, 8'h01, "R12");
        settle("R12");
        expect_status(1'b0, 8'h00, "R12");

        // R13: high address bits ignored
        wren(1'b0);
        run_pp(24'hFC0190, 3, 0, 1'b1, 1'b0, "R13");
        settle("R13");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule